// File: doc/BRIEF.md
# Erasable Read-Only Memory Device Model

This block is a synthesizable, clock-based model of a byte-wide read-only memory. The memory can be programmed once and then erased as a whole. Software-free test benches and system models put it on a shared data bus. The block decodes a bus mode from three active-low control lines and two digital level flags. One flag says the programming supply is raised. The other says the identification voltage is present on the ninth address line. From that mode the block either drives the stored byte or a fixed identification code, or keeps its bus driver off. A separate bus-enable output shows when the model drives the bus. A bench can then check that only one device drives a shared bus at a time.

Programming only ever clears bits. The byte on the data-in port is ANDed into the addressed word on the rising edge of the program strobe. The only way to set bits back to one is the erase input, which stands in for ultraviolet exposure. Erase walks the array one word per clock and writes all ones. When it finishes it raises a done flag. Reset starts the same fill, so the array comes up blank.

The array holds 2**ADDR_W words of DATA_W bits. The default is kept small for elaboration. The full-size device uses ADDR_W = 13, which gives 8192 bytes. Inputs are sampled on the clock, and the read data path is combinational.

Top module: `prom_model`

## Requirements
- R1: While reset is held, erase_done is 0. Once erase_done first rises after reset, every word reads 0xFF.
- R2: In the same cycle that ce_n=0, oe_n=0 and prog_n=1 hold and identification is not active, dq_oe is 1 and dq_out equals the stored word at addr.
- R3: Whenever ce_n=1, dq_oe is 0, whatever the other inputs are.
- R4: With ce_n=0, dq_oe is 0 when oe_n=1 or when prog_n=0.
- R5: A clock edge is a program edge when prog_n was 0 at the previous edge and is 1 now, with ce_n=0 and vpp_hi=1. At a program edge, the word at addr becomes its old value AND dq_in. From the next read onward, stored bits never change from 0 to 1 except by erase.
- R6: A strobe rise with vpp_hi=0, or with ce_n=1, leaves the stored word unchanged.
- R7: With vpp_hi=1 and the read conditions of R2 met, dq_out returns the stored word. This is the verify read.
- R8: With id_hv=1, vpp_hi=0 and the read conditions met, dq_oe is 1. dq_out is 0x9B when addr[0]=0 and 0x08 when addr[0]=1.
- R9: With id_hv=1 and vpp_hi=1, a read returns the stored word, not an identification code.
- R10: If erase_req is sampled at an edge while no fill is running, erase_done is 0 after that edge. It rises exactly 2**ADDR_W edges later, and then every word reads 0xFF. After that, erase_done stays 1 until the next erase_req.
- R11: While a fill is running, program edges and further erase_req pulses have no effect. The fill length and the all-ones result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; starts a blank fill |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output gate |
| prog_n | input | 1 | Active-low program strobe; the write happens on its rise |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identification voltage present on the ninth address line |
| dq_in | input | DATA_W | Byte to program |
| erase_req | input | 1 | Starts a whole-array fill with ones |
| dq_out | output | DATA_W | Read data, zero when not driven |
| dq_oe | output | 1 | Bus driver enable |
| erase_done | output | 1 | Fill finished; held until the next erase request |

## Verification
The assertions assume that all inputs change only between clock edges. The bit-clearing property also assumes that addr and the read controls stay stable for two samples before a comparison is made. The identification checks assume that the address lines other than bit 0 are low in that mode. The stimulus drives every input on the falling clock edge and samples outputs just after that edge. It holds the address and controls steady across each read. In identification mode it drives only addr[0].

// File: rtl/prom_pkg.sv
`timescale 1ns/1ps
package prom_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_PROGRAM,
        MODE_OUT_OFF,
        MODE_IDENT,
        MODE_READ
    } bus_mode_e;

    localparam logic [7:0] MFR_CODE = 8'h9B;
    localparam logic [7:0] DEV_CODE = 8'h08;

endpackage

// File: rtl/prom_mode_dec.sv
`timescale 1ns/1ps
module prom_mode_dec
    import prom_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      prog_n,
    input  logic      vpp_hi,
    input  logic      id_hv,
    output bus_mode_e mode
);

    always_comb begin
        if (ce_n) begin
            mode = MODE_STANDBY;
        end else if (!prog_n) begin
            mode = MODE_PROGRAM;
        end else if (oe_n) begin
            mode = MODE_OUT_OFF;
        end else if (id_hv && !vpp_hi) begin
            mode = MODE_IDENT;
        end else begin
            mode = MODE_READ;
        end
    end

endmodule

// File: rtl/prom_array.sv
`timescale 1ns/1ps
module prom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              fill,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Fill writes all ones; a program write can only clear bits.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= fill ? {DATA_W{1'b1}} : (mem[waddr] & wdata);
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/prom_ctrl.sv
`timescale 1ns/1ps
module prom_ctrl #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              prog_n,
    input  logic              vpp_hi,
    input  logic              erase_req,
    output logic              we,
    output logic              fill,
    output logic [ADDR_W-1:0] waddr,
    output logic              erase_done
);

    localparam int                DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              strobe;
        logic [ADDR_W-1:0] ptr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = prog_n;
        we          = 1'b0;
        fill        = 1'b0;
        waddr       = addr;
        if (st_q.busy) begin
            // Fill in progress: one word per clock; strobe and requests ignored.
            we    = 1'b1;
            fill  = 1'b1;
            waddr = st_q.ptr;
            if (st_q.ptr == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.ptr  = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end else if (erase_req) begin
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.ptr  = '0;
        end else if (!st_q.strobe && prog_n && !ce_n && vpp_hi) begin
            we = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy   <= 1'b1;
            st_q.done   <= 1'b0;
            st_q.strobe <= 1'b1;
            st_q.ptr    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign erase_done = st_q.done;

endmodule

// File: rtl/prom_model.sv
`timescale 1ns/1ps
module prom_model
    import prom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              erase_req,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              erase_done
);

    bus_mode_e         mode;
    logic              we;
    logic              fill;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] rdata;

    prom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .prog_n (prog_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .mode   (mode)
    );

    prom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .ce_n       (ce_n),
        .prog_n     (prog_n),
        .vpp_hi     (vpp_hi),
        .erase_req  (erase_req),
        .we         (we),
        .fill       (fill),
        .waddr      (waddr),
        .erase_done (erase_done)
    );

    prom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (we),
        .fill  (fill),
        .waddr (waddr),
        .wdata (dq_in),
        .raddr (addr),
        .rdata (rdata)
    );

    always_comb begin
        dq_out = '0;
        dq_oe  = 1'b0;
        case (mode)
            MODE_READ: begin
                dq_out = rdata;
                dq_oe  = 1'b1;
            end
            MODE_IDENT: begin
                dq_out = addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
                dq_oe  = 1'b1;
            end
            default: begin
                dq_out = '0;
                dq_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/prom_model_chk.sv
`timescale 1ns/1ps
module prom_model_chk
    import prom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              prog_n,
    input logic              vpp_hi,
    input logic              id_hv,
    input logic              erase_req,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              erase_done
);

    logic rd_ok;
    assign rd_ok = !ce_n && !oe_n && prog_n && !id_hv;

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dq_oe); // R3

    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && (oe_n || !prog_n)) |-> !dq_oe); // R4

    AST_IDENT_MFR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && prog_n && id_hv && !vpp_hi && !addr[0])
        |-> (dq_oe && dq_out == DATA_W'(MFR_CODE))); // R8

    AST_IDENT_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && prog_n && id_hv && !vpp_hi && addr[0])
        |-> (dq_oe && dq_out == DATA_W'(DEV_CODE))); // R8

    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && $past(rd_ok) && $stable(addr) && erase_done && $past(erase_done))
        |-> ((dq_out & ~$past(dq_out)) == '0)); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done && !erase_req) |=> erase_done); // R10

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done && erase_req) |=> !erase_done); // R10

endmodule

bind prom_model prom_model_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .prog_n     (prog_n),
    .vpp_hi     (vpp_hi),
    .id_hv      (id_hv),
    .erase_req  (erase_req),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .erase_done (erase_done)
);

// File: tb/test_prom_model.sv
`timescale 1ns/1ps
module test_prom_model;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          prog_n = 1'b1;
    logic          vpp_hi = 1'b0;
    logic          id_hv = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic          erase_req = 1'b0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          erase_done;

    int nvec = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    prom_model #(.ADDR_W(AW), .DATA_W(DW)) i_prom_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .prog_n(prog_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .dq_in(dq_in),
        .erase_req(erase_req), .dq_out(dq_out), .dq_oe(dq_oe),
        .erase_done(erase_done)
    );

    function automatic logic [7:0] pat_a(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] pat_b(input int a);
        return 8'(~(a ^ (a >> 3)) & 255);
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, input logic vpp, input logic [7:0] exp, input string req);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; prog_n = 1'b1;
        vpp_hi = vpp; id_hv = 1'b0;
        #1;
        check8(req, {7'b0, dq_oe}, 8'h01);
        check8(req, dq_out, exp);
        @(negedge clk);
    endtask

    task automatic pg(input int a, input logic [7:0] d, input logic ce, input logic vpp);
        addr = AW'(a); dq_in = d; ce_n = ce; oe_n = 1'b1; vpp_hi = vpp; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; vpp_hi = 1'b0;
    endtask

    task automatic wait_done();
        while (!erase_done) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        #1;
        check8("R1 reset done", {7'b0, erase_done}, 8'h00);
        check8("R3 reset standby", {7'b0, dq_oe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        wait_done();
        for (int a = 0; a < DEPTH; a++) rd(a, 1'b0, 8'hFF, "R1 blank");

        // R3 / R4: quiet bus cases
        addr = '0; ce_n = 1'b1; oe_n = 1'b0; prog_n = 1'b1; #1;
        check8("R3 standby oe low", {7'b0, dq_oe}, 8'h00);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; #1;
        check8("R4 output off", {7'b0, dq_oe}, 8'h00);
        @(negedge clk);
        oe_n = 1'b0; prog_n = 1'b0; #1;
        check8("R4 strobe low", {7'b0, dq_oe}, 8'h00);
        @(negedge clk);
        prog_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);

        // R5: program pattern A, read back
        for (int a = 0; a < DEPTH; a++) pg(a, pat_a(a), 1'b0, 1'b1);
        for (int a = 0; a < DEPTH; a++) rd(a, 1'b0, pat_a(a), "R5 R2 first pass");
        // R5: second pass ANDs in
        for (int a = 0; a < DEPTH; a++) pg(a, pat_b(a), 1'b0, 1'b1);
        for (int a = 0; a < DEPTH; a++) rd(a, 1'b1, pat_a(a) & pat_b(a), "R5 R7 verify and");

        // R6: inhibited program attempts
        for (int a = 0; a < 16; a++) begin
            pg(a, 8'h00, 1'b0, 1'b0);
            pg(a, 8'h00, 1'b1, 1'b1);
            rd(a, 1'b0, pat_a(a) & pat_b(a), "R6 inhibit");
        end

        // R8 / R9: identification
        addr = '0; ce_n = 1'b0; oe_n = 1'b0; prog_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b1; #1;
        check8("R8 mfr oe", {7'b0, dq_oe}, 8'h01);
        check8("R8 mfr code", dq_out, 8'h9B);
        @(negedge clk);
        addr = AW'(1); #1;
        check8("R8 dev code", dq_out, 8'h08);
        @(negedge clk);
        vpp_hi = 1'b1; #1;
        check8("R9 raised supply", dq_out, pat_a(1) & pat_b(1));
        @(negedge clk);
        id_hv = 1'b0; vpp_hi = 1'b0; ce_n = 1'b1;

        // R10 / R11: erase with ignored strobe and request during fill
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        #1;
        check8("R10 done falls", {7'b0, erase_done}, 8'h00);
        begin
            int cnt = 0;
            while (!erase_done && cnt < 3 * DEPTH) begin
                if (cnt == 8) begin
                    addr = '0; dq_in = 8'h00; ce_n = 1'b0; vpp_hi = 1'b1; prog_n = 1'b0;
                end
                if (cnt == 9) prog_n = 1'b1;
                if (cnt == 10) begin ce_n = 1'b1; vpp_hi = 1'b0; end
                if (cnt == 20) erase_req = 1'b1;
                if (cnt == 21) erase_req = 1'b0;
                @(negedge clk);
                cnt++;
            end
            check8("R10 R11 fill length lo", 8'(cnt), 8'(DEPTH));
            check8("R10 R11 fill length hi", 8'(cnt >> 8), 8'(DEPTH >> 8));
        end
        for (int a = 0; a < DEPTH; a++) rd(a, 1'b0, 8'hFF, "R10 R11 erased");
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check8("R10 done held", {7'b0, erase_done}, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule